// File: doc/BRIEF.md
# Systematic Reed-Solomon Encoder (255,249) over GF(2^8)

This block takes a stream of 8-bit message symbols and turns each message into a systematic Reed-Solomon codeword. The codeword has six check symbols, so it can correct up to three symbol errors. Each message symbol is forwarded to the output unchanged, one cycle after it is accepted. Meanwhile, a six-stage remainder register divides the message, shifted up by x^6, by the generator polynomial. When the source flags the last message symbol, the block appends the six remainder symbols as parity, most significant first.

The generator polynomial is the product of (x + alpha^j) for j = 0..5. Its field is built on the primitive polynomial x^8+x^4+x^3+x^2+1, with alpha = 0x02. The generator coefficients are derived during elaboration and become fixed constant multipliers.

A message may hold anywhere from 1 to 249 symbols. A shorter message acts as a full-length codeword whose leading symbols are zero and are not sent. The start flag marks the first symbol and clears the remainder in the same cycle, so a new block can follow the previous parity with no gap on the output. Input is ignored while parity is being emitted.

Top module: `rsenc_sys`

## Requirements
- R1: An accepted message symbol appears on `out_sym` on the next clock edge, unchanged. It is accompanied by `out_vld`=1, `out_par`=0 and `out_eob`=0.
- R2: The cycle after the last message symbol is output, exactly 6 parity symbols follow on consecutive cycles. Each has `out_vld`=1 and `out_par`=1.
- R3: Read the output block as a polynomial whose first symbol is the highest-degree coefficient. That polynomial evaluates to zero at alpha^0 through alpha^5 in GF(2^8), with the field polynomial 0x11D and alpha=0x02. This holds for a full 249-symbol message.
- R4: `out_eob` is 1 only together with the sixth parity symbol of a block.
- R5: Shortened messages of 1 to 248 symbols also give blocks that satisfy R3.
- R6: A symbol accepted with `in_sob`=1 starts a fresh remainder. This holds even when the previous block was abandoned without a last symbol.
- R7: `in_vld` is ignored during the six parity cycles. Such symbols never reach the output and do not change the parity.
- R8: During and after reset, `out_vld`, `out_par` and `out_eob` stay 0 until a symbol is accepted.
- R9: A new block's first symbol may be presented in the cycle after the sixth parity input slot. The output stream then continues with no idle cycle between blocks.
- R10: A cycle with `in_vld`=0 inside a message produces no output, and the remainder is held unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| in_sym | input | 8 | Message symbol |
| in_vld | input | 1 | `in_sym` carries a symbol this cycle |
| in_sob | input | 1 | First symbol of a block |
| in_last | input | 1 | Last message symbol of a block |
| out_sym | output | 8 | Codeword symbol |
| out_vld | output | 1 | `out_sym` is valid |
| out_par | output | 1 | `out_sym` is a parity symbol |
| out_eob | output | 1 | Final parity symbol of the block |

## Verification
A corrupted remainder stage or a wrong feedback tap leaves the message symbols untouched. It shows only in the parity symbols, which appear from 2 to 7 cycles after the last message symbol is accepted. Any such fault makes at least one of the six root evaluations of the output block nonzero. A failed clear on the start flag shows up in the same way, but in the block after the affected one. A fault in the parity counter shows up directly as a wrong number of `out_par` cycles or a misplaced `out_eob`, within seven cycles of the last flag.

// File: rtl/rsenc_pkg.sv
package rsenc_pkg;

  localparam int unsigned SYM_W   = 8;
  localparam logic [8:0]  FLD_POL = 9'h11D;
  localparam int unsigned MAX_PAR = 16;

  typedef logic [SYM_W-1:0] sym_t;
  typedef logic [MAX_PAR:0][SYM_W-1:0] gen_t;

  // GF(2^8) product, shift-and-add with reduction by the field polynomial
  function automatic sym_t gf_mul(sym_t a, sym_t b);
    sym_t acc;
    sym_t x;
    acc = '0;
    x   = a;
    for (int i = 0; i < SYM_W; i++) begin
      if (b[i]) acc = acc ^ x;
      if (x[SYM_W-1]) x = sym_t'(x << 1) ^ FLD_POL[SYM_W-1:0];
      else            x = sym_t'(x << 1);
    end
    return acc;
  endfunction

  function automatic sym_t gf_apow(int unsigned e);
    sym_t r;
    r = sym_t'(1);
    for (int unsigned i = 0; i < e; i++) r = gf_mul(r, sym_t'(2));
    return r;
  endfunction

  // coefficients of prod_{j} (x + alpha^(first+j)), index = power of x
  function automatic gen_t gen_poly(int unsigned npar, int unsigned first);
    gen_t g;
    sym_t rt;
    g    = '0;
    g[0] = sym_t'(1);
    for (int unsigned j = 0; j < npar; j++) begin
      rt = gf_apow(first + j);
      for (int i = MAX_PAR; i >= 1; i--) g[i] = g[i-1] ^ gf_mul(g[i], rt);
      g[0] = gf_mul(g[0], rt);
    end
    return g;
  endfunction

endpackage

// File: rtl/gf_cmul.sv
module gf_cmul
  import rsenc_pkg::*;
#(
  parameter sym_t COEF = 8'h01
) (
  input  sym_t a,
  output sym_t y
);

  // constant operand: reduces to a fixed XOR network
  always_comb y = gf_mul(a, COEF);

endmodule

// File: rtl/rsenc_ctrl.sv
module rsenc_ctrl #(
  parameter int unsigned NPAR = 6
) (
  input  logic clk,
  input  logic rst_n,
  input  logic in_vld,
  input  logic in_last,
  output logic accept,
  output logic par_busy,
  output logic par_final
);

  localparam int unsigned CNT_W = (NPAR > 1) ? $clog2(NPAR) : 1;
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(NPAR - 1);

  logic             busy_q, busy_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             st_en;

  assign accept    = in_vld & ~busy_q;
  assign par_busy  = busy_q;
  assign par_final = busy_q & (cnt_q == CNT_LAST);

  always_comb begin
    busy_d = busy_q;
    cnt_d  = cnt_q;
    st_en  = 1'b0;
    if (accept && in_last) begin
      busy_d = 1'b1;
      cnt_d  = '0;
      st_en  = 1'b1;
    end else if (busy_q) begin
      st_en = 1'b1;
      if (par_final) begin
        busy_d = 1'b0;
        cnt_d  = '0;
      end else begin
        cnt_d = cnt_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
    end else if (st_en) begin
      busy_q <= busy_d;
      cnt_q  <= cnt_d;
    end
  end

endmodule

// File: rtl/rsenc_lfsr.sv
module rsenc_lfsr
  import rsenc_pkg::*;
#(
  parameter int unsigned NPAR = 6,
  parameter int unsigned FCR  = 0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic shift_en,
  input  logic clr,
  input  logic fb_en,
  input  sym_t din,
  output sym_t rem_top
);

  localparam gen_t GEN = gen_poly(NPAR, FCR);

  logic [NPAR-1:0][SYM_W-1:0] rem_q, rem_d, rem_base, prod;
  sym_t fb;

  always_comb begin
    for (int i = 0; i < NPAR; i++) rem_base[i] = clr ? '0 : rem_q[i];
    fb = fb_en ? (din ^ rem_base[NPAR-1]) : '0;
  end

  for (genvar i = 0; i < NPAR; i++) begin : g_tap
    gf_cmul #(.COEF(GEN[i])) u_mul (
      .a (fb),
      .y (prod[i])
    );
  end

  always_comb begin
    rem_d[0] = prod[0];
    for (int i = 1; i < NPAR; i++) rem_d[i] = rem_base[i-1] ^ prod[i];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rem_q <= '0;
    else if (shift_en) rem_q <= rem_d;
  end

  assign rem_top = rem_q[NPAR-1];

endmodule

// File: rtl/rsenc_sys.sv
module rsenc_sys
  import rsenc_pkg::*;
#(
  parameter int unsigned NPAR = 6,
  parameter int unsigned FCR  = 0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [SYM_W-1:0] in_sym,
  input  logic             in_vld,
  input  logic             in_sob,
  input  logic             in_last,
  output logic [SYM_W-1:0] out_sym,
  output logic             out_vld,
  output logic             out_par,
  output logic             out_eob
);

  logic accept, par_busy, par_final;
  sym_t rem_top;

  rsenc_ctrl #(.NPAR(NPAR)) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_vld    (in_vld),
    .in_last   (in_last),
    .accept    (accept),
    .par_busy  (par_busy),
    .par_final (par_final)
  );

  rsenc_lfsr #(.NPAR(NPAR), .FCR(FCR)) u_lfsr (
    .clk      (clk),
    .rst_n    (rst_n),
    .shift_en (accept | par_busy),
    .clr      (accept & in_sob),
    .fb_en    (accept),
    .din      (in_sym),
    .rem_top  (rem_top)
  );

  sym_t sym_q, sym_d;
  logic vld_q, vld_d, par_q, par_d, eob_q, eob_d, sym_en;

  always_comb begin
    sym_d  = sym_q;
    sym_en = 1'b0;
    vld_d  = 1'b0;
    par_d  = 1'b0;
    eob_d  = 1'b0;
    if (accept) begin
      sym_d  = in_sym;
      sym_en = 1'b1;
      vld_d  = 1'b1;
    end else if (par_busy) begin
      sym_d  = rem_top;
      sym_en = 1'b1;
      vld_d  = 1'b1;
      par_d  = 1'b1;
      eob_d  = par_final;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q <= 1'b0;
      par_q <= 1'b0;
      eob_q <= 1'b0;
    end else begin
      vld_q <= vld_d;
      par_q <= par_d;
      eob_q <= eob_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sym_q <= '0;
    else if (sym_en) sym_q <= sym_d;
  end

  assign out_sym = sym_q;
  assign out_vld = vld_q;
  assign out_par = par_q;
  assign out_eob = eob_q;

endmodule

// File: rtl/rsenc_chk.sv
module rsenc_chk #(
  parameter int unsigned NPAR = 6
) (
  input logic       clk,
  input logic       rst_n,
  input logic [7:0] in_sym,
  input logic       in_vld,
  input logic       in_last,
  input logic       par_busy,
  input logic [7:0] out_sym,
  input logic       out_vld,
  input logic       out_par,
  input logic       out_eob
);

  logic [7:0] run_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) run_cnt <= '0;
    else if (out_par) run_cnt <= out_eob ? 8'd0 : run_cnt + 8'd1;
    else run_cnt <= '0;
  end

  a_r1_pass_through: assert property (@(posedge clk) disable iff (!rst_n)
    (in_vld && !par_busy) |=> (out_vld && !out_par && !out_eob && out_sym == $past(in_sym)));

  a_r2_parity_follows: assert property (@(posedge clk) disable iff (!rst_n)
    (in_vld && !par_busy && in_last) |=> ##1 (out_vld && out_par));

  a_r2_parity_run: assert property (@(posedge clk) disable iff (!rst_n)
    (out_par && !out_eob) |=> out_par);

  a_r2_run_ends: assert property (@(posedge clk) disable iff (!rst_n)
    (out_par && run_cnt == 8'(NPAR - 1)) |-> out_eob);

  a_r4_eob_place: assert property (@(posedge clk) disable iff (!rst_n)
    out_eob |-> (out_vld && out_par && run_cnt == 8'(NPAR - 1)));

  a_r7_parity_wins: assert property (@(posedge clk) disable iff (!rst_n)
    par_busy |=> (out_vld && out_par));

  a_r10_idle_gap: assert property (@(posedge clk) disable iff (!rst_n)
    (!in_vld && !par_busy) |=> !out_vld);

endmodule

bind rsenc_sys rsenc_chk #(.NPAR(NPAR)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .in_sym   (in_sym),
  .in_vld   (in_vld),
  .in_last  (in_last),
  .par_busy (par_busy),
  .out_sym  (out_sym),
  .out_vld  (out_vld),
  .out_par  (out_par),
  .out_eob  (out_eob)
);

// File: tb/rsenc_sys_tb_top.sv
module rsenc_sys_tb_top;

  localparam int NP   = 6;
  localparam int CAPN = 4096;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] in_sym = '0;
  logic       in_vld = 1'b0, in_sob = 1'b0, in_last = 1'b0;
  logic [7:0] out_sym;
  logic       out_vld, out_par, out_eob;

  int checks = 0;
  int errors = 0;
  int cyc = 0;

  logic [7:0] cap_sym[CAPN];
  bit         cap_par[CAPN];
  bit         cap_eob[CAPN];
  int         cap_cyc[CAPN];
  int         cap_n = 0;

  logic [7:0] blk[4][256];
  int         blen[4];

  always #10 clk = ~clk;

  rsenc_sys dut_i (
    .clk(clk), .rst_n(rst_n), .in_sym(in_sym), .in_vld(in_vld),
    .in_sob(in_sob), .in_last(in_last), .out_sym(out_sym),
    .out_vld(out_vld), .out_par(out_par), .out_eob(out_eob)
  );

  always @(posedge clk) cyc <= cyc + 1;

  always @(negedge clk) begin
    if (rst_n && out_vld) begin
      if (cap_n < CAPN) begin
        cap_sym[cap_n] = out_sym;
        cap_par[cap_n] = out_par;
        cap_eob[cap_n] = out_eob;
        cap_cyc[cap_n] = cyc;
      end
      cap_n = cap_n + 1;
    end
  end

  function automatic logic [7:0] gmul(logic [7:0] a, logic [7:0] b);
    logic [7:0] r = '0;
    logic [7:0] x = a;
    for (int i = 0; i < 8; i++) begin
      if (b[i]) r ^= x;
      x = x[7] ? (8'(x << 1) ^ 8'h1D) : 8'(x << 1);
    end
    return r;
  endfunction

  function automatic logic [7:0] pat(int s, int i);
    return 8'((s * 61 + i * 29 + i * i * 7) ^ (s * 5 + 1));
  endfunction

  task automatic check(bit ok, string req, string what, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic idle(int n);
    repeat (n) begin
      @(negedge clk);
      in_vld = 1'b0; in_sob = 1'b0; in_last = 1'b0;
    end
  endtask

  // drives one message plus the parity window; noisy = drive junk there
  task automatic send_msg(int b, int len, int seed, int gap, bit noisy);
    blen[b] = len;
    for (int i = 0; i < len; i++) begin
      if (gap > 0 && i > 0 && (i % gap) == 0) idle(1);
      @(negedge clk);
      blk[b][i] = pat(seed, i);
      in_sym = blk[b][i]; in_vld = 1'b1;
      in_sob = (i == 0); in_last = (i == len - 1);
    end
    for (int p = 0; p < NP; p++) begin
      @(negedge clk);
      if (noisy) begin
        in_vld = 1'b1; in_sym = pat(seed + 50, p);
        in_sob = p[0]; in_last = 1'b1;
      end else begin
        in_vld = 1'b0; in_sob = 1'b0; in_last = 1'b0;
      end
    end
  endtask

  task automatic drain(output int n);
    idle(8);
    #1 n = cap_n;
  endtask

  task automatic verify_block(int b, int base, string req);
    int len = blen[b];
    int bad = 0;
    int bi = 0;
    logic [7:0] s, rt;
    for (int i = 0; i < len; i++) begin
      if (cap_sym[base+i] !== blk[b][i] || cap_par[base+i] || cap_eob[base+i]) begin
        if (bad == 0) bi = i;
        bad++;
      end
    end
    check(bad == 0, "R1", "message symbol", int'(cap_sym[base+bi]), int'(blk[b][bi]));
    bad = 0;
    for (int p = 0; p < NP; p++) if (!cap_par[base+len+p]) bad++;
    check(bad == 0, "R2", "parity flag count missing", bad, 0);
    bad = 0;
    for (int p = 0; p < NP; p++) if (cap_eob[base+len+p] != (p == NP - 1)) bad++;
    check(bad == 0, "R4", "eob placement errors", bad, 0);
    rt = 8'h01;
    for (int j = 0; j < NP; j++) begin
      s = '0;
      for (int i = 0; i < len + NP; i++) s = gmul(s, rt) ^ cap_sym[base+i];
      check(s == 8'h00, req, $sformatf("syndrome %0d", j), int'(s), 0);
      rt = gmul(rt, 8'h02);
    end
  endtask

  task automatic t_reset();
    repeat (3) @(negedge clk);
    check(!out_vld && !out_par && !out_eob, "R8", "flags in reset",
          int'({out_vld, out_par, out_eob}), 0);
    rst_n = 1'b1;
    idle(4);
    check(!out_vld && !out_par && !out_eob && cap_n == 0, "R8", "flags after reset",
          int'({out_vld, out_par, out_eob}), 0);
  endtask

  task automatic t_full();
    int b0, b1;
    drain(b0);
    send_msg(0, 249, 1, 0, 1'b0);
    drain(b1);
    check(b1 - b0 == 255, "R2", "full block length", b1 - b0, 255);
    verify_block(0, b0, "R3");
  endtask

  task automatic t_short();
    int lens[3] = '{1, 2, 17};
    int b0, b1;
    foreach (lens[k]) begin
      drain(b0);
      send_msg(0, lens[k], 7 + k, 0, 1'b0);
      drain(b1);
      check(b1 - b0 == lens[k] + NP, "R5", "short block length", b1 - b0, lens[k] + NP);
      verify_block(0, b0, "R5");
    end
  endtask

  task automatic t_back_to_back();
    int b0, b1, base;
    drain(b0);
    send_msg(0, 5, 21, 0, 1'b1);
    send_msg(1, 9, 22, 0, 1'b1);
    send_msg(2, 12, 23, 0, 1'b1);
    drain(b1);
    check(b1 - b0 == 26 + 3 * NP, "R7", "symbols with junk in parity slots", b1 - b0, 26 + 3 * NP);
    base = b0;
    for (int k = 0; k < 3; k++) begin
      verify_block(k, base, "R7");
      if (k > 0)
        check(cap_cyc[base] == cap_cyc[base-1] + 1, "R9", "output gap between blocks",
              cap_cyc[base] - cap_cyc[base-1], 1);
      base += blen[k] + NP;
    end
  endtask

  task automatic t_gaps();
    int b0, b1;
    drain(b0);
    send_msg(0, 20, 31, 3, 1'b0);
    drain(b1);
    check(b1 - b0 == 20 + NP, "R10", "output count with idle gaps", b1 - b0, 20 + NP);
    verify_block(0, b0, "R10");
  endtask

  task automatic t_restart();
    int b0, b1;
    drain(b0);
    for (int i = 0; i < 7; i++) begin
      @(negedge clk);
      in_vld = 1'b1; in_sob = (i == 0); in_last = 1'b0; in_sym = pat(40, i);
    end
    send_msg(0, 10, 41, 0, 1'b0);
    drain(b1);
    check(b1 - b0 == 7 + 10 + NP, "R6", "restart output count", b1 - b0, 17 + NP);
    verify_block(0, b0 + 7, "R6");
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    t_reset();
    t_full();
    t_short();
    t_back_to_back();
    t_gaps();
    t_restart();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule